// File: doc/BRIEF.md
# Configurable Serial Receiver Deframer

This block recovers one character per frame from a single serial input line and hands each finished word to a downstream FIFO over a valid/ready pair. Every part of the frame can be configured on its own. The start bit, the parity bit and the stop region can each be switched off. The word length runs from 5 to 9 bits. Parity can be odd, even, forced high or forced low. The stop region can last half a bit, one bit, one and a half bits or two bits. The bit period comes from a 16-bit divisor input given in clock cycles.

For multiprocessor addressing, a reference bit can be compared against the last data bit of each word. Depending on the mode, the comparison gates storage of the word, raises a frame error, or the last data bit is copied into the reference bit. Frame, parity and overrun errors each set their own sticky flag, and an enable gates the combined error interrupt. The receiver also has three frame-level controls: an enable, an inhibit that lets the current frame finish and then ignores further traffic, and a one-shot mode that accepts exactly one frame while the receiver is disabled.

Top module: `cfg_uart_rx`

## Requirements
- R1: After reset, out_valid_o, busy_o, all three error flags, err_irq_o and ref_bit_o are 0.
- R2: A new frame starts only on a high-to-low transition of the line while the receiver is idle. When the start bit is enabled, the line must still be low half a bit period later, otherwise the receiver returns to idle and delivers nothing. Bits are sampled at mid-bit, divisor_i clock cycles apart, least significant bit first. divisor_i must be at least 8.
- R3: data_len_i codes 0..3 select 5..8 data bits. Code 4 selects 9 bits with the 9th bit delivered on out_data_o[8]. Code 5 selects 9 bits with out_data_o[8] forced to 0. Output bits above the word length are 0.
- R4: parity_mode_i selects 0 odd, 1 even, 2 mark (bit must be 1) or 3 space (bit must be 0). The parity covers all received data bits. A mismatch sets the parity flag, and the word is still delivered.
- R5: With stop enabled, stop_len_i codes 0..3 give 1..4 half-bit slots. The line is checked at the centre of each slot. A low sample sets the frame flag, and the word is still delivered.
- R6: The start, parity and stop elements are enabled independently, and a disabled element is not expected. With the start bit disabled, the falling edge is the leading edge of data bit 0. With stop disabled, the frame ends at the last data or parity sample.
- R7: match_mode_i: 0 no matching. 1 delivers a word only when its last data bit equals ref_bit_o. 2 sets the frame flag when the last data bit equals ref_bit_o. 3 copies the last data bit into ref_bit_o. A write on ref_bit_wr_i loads ref_bit_o, and a capture in mode 3 in the same cycle takes priority.
- R8: invert_i=1 inverts rx_i before deframing, so the idle line is low.
- R9: A frame is accepted only if inhibit_i=0 and either rx_enable_i=1, or one_shot_i=1 and no frame has yet completed under one-shot. The one-shot allowance is reset while one_shot_i=0. A frame already in progress always completes.
- R10: out_valid_o and out_data_o hold until out_ready_i is high. If a word completes while out_valid_o=1 and out_ready_i=0, the overrun flag is set, the new word is dropped and the held word is kept.
- R11: flag_wdata_i bit 0 is frame, bit 1 parity, bit 2 overrun. A pulse on flag_wr_i loads the three flags, writing 0 to clear and 1 to force. A hardware set in the same cycle wins. err_irq_o = err_irq_en_i AND (any flag set).
- R12: busy_o is high from an accepted start edge until the word is handed to the output stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial input line |
| invert_i | input | 1 | Invert the serial input |
| divisor_i | input | 16 | Bit period in clock cycles |
| start_en_i | input | 1 | Expect a start bit |
| parity_en_i | input | 1 | Expect a parity bit |
| parity_mode_i | input | 2 | Parity kind (R4 encoding) |
| stop_en_i | input | 1 | Expect a stop region |
| stop_len_i | input | 2 | Stop length in half-bit slots minus one |
| data_len_i | input | 3 | Word length code (R3 encoding) |
| match_mode_i | input | 2 | Match function (R7 encoding) |
| rx_enable_i | input | 1 | Receiver enable |
| one_shot_i | input | 1 | Allow one frame while disabled |
| inhibit_i | input | 1 | Ignore new frames |
| ref_bit_wr_i | input | 1 | Load the reference bit |
| ref_bit_wdata_i | input | 1 | Value for the reference bit |
| ref_bit_o | output | 1 | Reference bit |
| flag_wr_i | input | 1 | Load the error flags |
| flag_wdata_i | input | 3 | Flag values {overrun, parity, frame} |
| err_irq_en_i | input | 1 | Error interrupt enable |
| frame_err_o | output | 1 | Sticky frame error flag |
| parity_err_o | output | 1 | Sticky parity error flag |
| overrun_err_o | output | 1 | Sticky overrun flag |
| err_irq_o | output | 1 | Combined error interrupt |
| busy_o | output | 1 | Frame in progress |
| out_valid_o | output | 1 | Received word valid |
| out_ready_i | input | 1 | Downstream accepts the word |
| out_data_o | output | 9 | Received word |

## Verification
The assertions check on every cycle that the output word is held while it waits for ready, that an overrun keeps the held word and raises its flag, that the error flags stay set until written, that capture mode copies the last bit into the reference, and that the bit timer only ticks and frames only begin in the right states. Only the bench's frame scenarios show the bit-level behaviour: mid-bit sampling order, the decoding of the length, parity and stop codes, optional elements, inversion, match gating, and the enable, inhibit and one-shot sequencing.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int unsigned WORD_W = 9;

  localparam logic [1:0] PAR_ODD   = 2'd0;
  localparam logic [1:0] PAR_EVEN  = 2'd1;
  localparam logic [1:0] PAR_MARK  = 2'd2;
  localparam logic [1:0] PAR_SPACE = 2'd3;

  localparam logic [1:0] MATCH_OFF     = 2'd0;
  localparam logic [1:0] MATCH_ACCEPT  = 2'd1;
  localparam logic [1:0] MATCH_FRAME   = 2'd2;
  localparam logic [1:0] MATCH_CAPTURE = 2'd3;

  localparam logic [2:0] LEN_9_STORE = 3'd4;
  localparam logic [2:0] LEN_9_MATCH = 3'd5;

  typedef enum logic [1:0] {WAIT_FULL, WAIT_HALF, WAIT_3Q} wait_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP, ST_DONE
  } rx_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic              par_err;
    logic              frm_err;
    logic              accept;
    logic              last_bit;
  } rx_result_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic invert_i,
  output logic line_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   din;

  assign din = rx_i ^ invert_i;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign line_o = sync_q[SYNC_STAGES-1];
  assign fall_o = prev_q & ~line_o;
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer
  import serial_rx_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic             load_i,
  input  wait_sel_e        sel_i,
  input  logic             halt_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] raw, reload, cnt_q;
  logic             run_q;

  always_comb begin
    unique case (sel_i)
      WAIT_HALF: raw = divisor_i >> 1;
      WAIT_3Q:   raw = (divisor_i >> 1) + (divisor_i >> 2);
      default:   raw = divisor_i;
    endcase
    reload = (raw == '0) ? DIV_W'(1) : raw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (halt_i) begin
      run_q <= 1'b0;
    end else if (load_i) begin
      run_q <= 1'b1;
      cnt_q <= reload - DIV_W'(1);
    end else if (run_q && cnt_q != '0) begin
      cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  assign tick_o = run_q && (cnt_q == '0);

  // R2: a running countdown keeps running until told otherwise
  assert_timer_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !halt_i) |=> run_q);
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import serial_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  input  logic       fall_i,
  input  logic       tick_i,
  input  logic       start_en_i,
  input  logic       parity_en_i,
  input  logic [1:0] parity_mode_i,
  input  logic       stop_en_i,
  input  logic [1:0] stop_len_i,
  input  logic [2:0] data_len_i,
  input  logic [1:0] match_mode_i,
  input  logic       ref_bit_i,
  input  logic       rx_enable_i,
  input  logic       one_shot_i,
  input  logic       inhibit_i,
  output logic       timer_load_o,
  output wait_sel_e  timer_sel_o,
  output logic       timer_halt_o,
  output logic       busy_o,
  output logic       done_o,
  output rx_result_t result_o
);
  rx_state_e         state_q, state_d;
  logic [3:0]        idx_q, idx_d, last_idx;
  logic [1:0]        slot_q, slot_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic              par_q, par_d, perr_q, perr_d, ferr_q, ferr_d;
  logic              last_q, last_d, shot_q, shot_d;
  logic              allow;

  always_comb begin
    unique case (data_len_i)
      3'd0: last_idx = 4'd4;
      3'd1: last_idx = 4'd5;
      3'd2: last_idx = 4'd6;
      LEN_9_STORE, LEN_9_MATCH: last_idx = 4'd8;
      default: last_idx = 4'd7;
    endcase
  end

  assign allow = !inhibit_i && (rx_enable_i || (one_shot_i && !shot_q));

  always_comb begin
    state_d      = state_q;
    idx_d        = idx_q;
    slot_d       = slot_q;
    data_d       = data_q;
    par_d        = par_q;
    perr_d       = perr_q;
    ferr_d       = ferr_q;
    last_d       = last_q;
    shot_d       = one_shot_i ? shot_q : 1'b0;
    timer_load_o = 1'b0;
    timer_sel_o  = WAIT_FULL;
    timer_halt_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fall_i && allow) begin
          timer_load_o = 1'b1;
          timer_sel_o  = WAIT_HALF;
          data_d = '0; par_d = 1'b0; perr_d = 1'b0; ferr_d = 1'b0;
          idx_d  = '0; slot_d = '0;
          state_d = start_en_i ? ST_START : ST_DATA;
        end
      end
      ST_START: begin
        if (tick_i) begin
          if (!line_i) begin
            timer_load_o = 1'b1;
            state_d = ST_DATA;
          end else begin
            timer_halt_o = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_DATA: begin
        if (tick_i) begin
          data_d[idx_q] = line_i;
          par_d = par_q ^ line_i;
          if (idx_q == last_idx) begin
            last_d = line_i;
            if (parity_en_i) begin
              timer_load_o = 1'b1;
              state_d = ST_PARITY;
            end else if (stop_en_i) begin
              timer_load_o = 1'b1;
              timer_sel_o  = WAIT_3Q;
              state_d = ST_STOP;
            end else begin
              timer_halt_o = 1'b1;
              state_d = ST_DONE;
            end
          end else begin
            idx_d = idx_q + 4'd1;
            timer_load_o = 1'b1;
          end
        end
      end
      ST_PARITY: begin
        if (tick_i) begin
          unique case (parity_mode_i)
            PAR_ODD:  perr_d = !(par_q ^ line_i);
            PAR_EVEN: perr_d = par_q ^ line_i;
            PAR_MARK: perr_d = !line_i;
            default:  perr_d = line_i;
          endcase
          if (stop_en_i) begin
            timer_load_o = 1'b1;
            timer_sel_o  = WAIT_3Q;
            state_d = ST_STOP;
          end else begin
            timer_halt_o = 1'b1;
            state_d = ST_DONE;
          end
        end
      end
      ST_STOP: begin
        if (tick_i) begin
          if (!line_i) ferr_d = 1'b1;
          if (slot_q == stop_len_i) begin
            timer_halt_o = 1'b1;
            state_d = ST_DONE;
          end else begin
            slot_d = slot_q + 2'd1;
            timer_load_o = 1'b1;
            timer_sel_o  = WAIT_HALF;
          end
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
        if (!rx_enable_i && one_shot_i) shot_d = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      slot_q  <= '0;
      data_q  <= '0;
      par_q   <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      last_q  <= 1'b0;
      shot_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      slot_q  <= slot_d;
      data_q  <= data_d;
      par_q   <= par_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      last_q  <= last_d;
      shot_q  <= shot_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

  always_comb begin
    result_o.word     = data_q;
    if (data_len_i == LEN_9_MATCH) result_o.word[WORD_W-1] = 1'b0;
    result_o.par_err  = perr_q;
    result_o.frm_err  = ferr_q | ((match_mode_i == MATCH_FRAME) && (last_q == ref_bit_i));
    result_o.accept   = !((match_mode_i == MATCH_ACCEPT) && (last_q != ref_bit_i));
    result_o.last_bit = last_q;
  end

  assert_frame_needs_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(fall_i) && $past(allow)));
  assert_tick_only_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> busy_o);
  assert_done_after_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
endmodule

// File: rtl/rx_status.sv
module rx_status
  import serial_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  rx_result_t        result_i,
  input  logic [1:0]        match_mode_i,
  input  logic              out_ready_i,
  input  logic              err_irq_en_i,
  input  logic              flag_wr_i,
  input  logic [2:0]        flag_wdata_i,
  input  logic              ref_wr_i,
  input  logic              ref_wdata_i,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_data_o,
  output logic [2:0]        flags_o,
  output logic              err_irq_o,
  output logic              ref_bit_o
);
  logic       store_req, ovr_set;
  logic [2:0] set_vec, flags_q;

  assign store_req = done_i & result_i.accept;
  assign ovr_set   = store_req & out_valid_o & ~out_ready_i;
  assign set_vec   = {ovr_set, done_i & result_i.par_err, done_i & result_i.frm_err};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (store_req && !ovr_set) begin
      out_valid_o <= 1'b1;
      out_data_o  <= result_i.word;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flag_wr_i ? flag_wdata_i : flags_q) | set_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      ref_bit_o <= 1'b0;
    else if (done_i && match_mode_i == MATCH_CAPTURE) ref_bit_o <= result_i.last_bit;
    else if (ref_wr_i)                                ref_bit_o <= ref_wdata_i;
  end

  assign flags_o   = flags_q;
  assign err_irq_o = err_irq_en_i & (|flags_q);

  assert_hold_until_taken_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o);
  assert_overrun_keeps_word_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && result_i.accept && out_valid_o && !out_ready_i) |=> (flags_o[2] && $stable(out_data_o)));
  assert_flag_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[0] && !flag_wr_i) |=> flags_o[0]);
  assert_ref_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && match_mode_i == MATCH_CAPTURE) |=> (ref_bit_o == $past(result_i.last_bit)));
endmodule

// File: rtl/cfg_uart_rx.sv
module cfg_uart_rx
  import serial_rx_pkg::*;
#(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              invert_i,
  input  logic [DIV_W-1:0]  divisor_i,
  input  logic              start_en_i,
  input  logic              parity_en_i,
  input  logic [1:0]        parity_mode_i,
  input  logic              stop_en_i,
  input  logic [1:0]        stop_len_i,
  input  logic [2:0]        data_len_i,
  input  logic [1:0]        match_mode_i,
  input  logic              rx_enable_i,
  input  logic              one_shot_i,
  input  logic              inhibit_i,
  input  logic              ref_bit_wr_i,
  input  logic              ref_bit_wdata_i,
  output logic              ref_bit_o,
  input  logic              flag_wr_i,
  input  logic [2:0]        flag_wdata_i,
  input  logic              err_irq_en_i,
  output logic              frame_err_o,
  output logic              parity_err_o,
  output logic              overrun_err_o,
  output logic              err_irq_o,
  output logic              busy_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o
);
  logic       line, fall, tick, t_load, t_halt, done;
  wait_sel_e  t_sel;
  rx_result_t result;
  logic [2:0] flags;

  rx_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .rx_i, .invert_i, .line_o(line), .fall_o(fall)
  );

  rx_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i, .rst_ni, .divisor_i, .load_i(t_load), .sel_i(t_sel),
    .halt_i(t_halt), .tick_o(tick)
  );

  rx_deframer u_deframer (
    .clk_i, .rst_ni, .line_i(line), .fall_i(fall), .tick_i(tick),
    .start_en_i, .parity_en_i, .parity_mode_i, .stop_en_i, .stop_len_i,
    .data_len_i, .match_mode_i, .ref_bit_i(ref_bit_o), .rx_enable_i,
    .one_shot_i, .inhibit_i, .timer_load_o(t_load), .timer_sel_o(t_sel),
    .timer_halt_o(t_halt), .busy_o, .done_o(done), .result_o(result)
  );

  rx_status u_status (
    .clk_i, .rst_ni, .done_i(done), .result_i(result), .match_mode_i,
    .out_ready_i, .err_irq_en_i, .flag_wr_i, .flag_wdata_i,
    .ref_wr_i(ref_bit_wr_i), .ref_wdata_i(ref_bit_wdata_i),
    .out_valid_o, .out_data_o, .flags_o(flags), .err_irq_o, .ref_bit_o
  );

  assign frame_err_o   = flags[0];
  assign parity_err_o  = flags[1];
  assign overrun_err_o = flags[2];
endmodule

// File: tb/cfg_uart_rx_tb_top.sv
module cfg_uart_rx_tb_top;
  localparam int DIV = 32;

  typedef struct packed {
    logic [2:0] len;
    logic       pen;
    logic [1:0] pmode;
    logic       sten;
    logic [1:0] slen;
    logic       stren;
    logic [1:0] mm;
    logic       ref_b;
    logic [8:0] data;
    logic       badp;
    logic       bads;
    logic       exp_st;
    logic [8:0] exp_w;
    logic       exp_pe;
    logic       exp_fe;
    logic       exp_ref;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{3'd0,1'b0,2'd0,1'b1,2'd1,1'b1,2'd0,1'b0,9'h015,1'b0,1'b0,1'b1,9'h015,1'b0,1'b0,1'b0},
    '{3'd3,1'b1,2'd1,1'b1,2'd1,1'b1,2'd0,1'b0,9'h0A5,1'b0,1'b0,1'b1,9'h0A5,1'b0,1'b0,1'b0},
    '{3'd3,1'b1,2'd0,1'b1,2'd3,1'b1,2'd0,1'b0,9'h03C,1'b0,1'b0,1'b1,9'h03C,1'b0,1'b0,1'b0},
    '{3'd2,1'b1,2'd2,1'b1,2'd0,1'b1,2'd0,1'b0,9'h07F,1'b0,1'b0,1'b1,9'h07F,1'b0,1'b0,1'b0},
    '{3'd1,1'b1,2'd3,1'b1,2'd2,1'b1,2'd0,1'b0,9'h02A,1'b0,1'b0,1'b1,9'h02A,1'b0,1'b0,1'b0},
    '{3'd4,1'b0,2'd0,1'b1,2'd1,1'b1,2'd0,1'b0,9'h1A5,1'b0,1'b0,1'b1,9'h1A5,1'b0,1'b0,1'b0},
    '{3'd5,1'b0,2'd0,1'b1,2'd1,1'b1,2'd0,1'b0,9'h1A5,1'b0,1'b0,1'b1,9'h0A5,1'b0,1'b0,1'b0},
    '{3'd3,1'b1,2'd1,1'b1,2'd1,1'b1,2'd0,1'b0,9'h081,1'b1,1'b0,1'b1,9'h081,1'b1,1'b0,1'b0},
    '{3'd3,1'b0,2'd0,1'b1,2'd1,1'b1,2'd0,1'b0,9'h066,1'b0,1'b1,1'b1,9'h066,1'b0,1'b1,1'b0},
    '{3'd3,1'b0,2'd0,1'b1,2'd1,1'b0,2'd0,1'b0,9'h05A,1'b0,1'b0,1'b1,9'h05A,1'b0,1'b0,1'b0},
    '{3'd0,1'b0,2'd0,1'b0,2'd1,1'b1,2'd0,1'b0,9'h00E,1'b0,1'b0,1'b1,9'h00E,1'b0,1'b0,1'b0},
    '{3'd5,1'b0,2'd0,1'b1,2'd1,1'b1,2'd1,1'b1,9'h1A5,1'b0,1'b0,1'b1,9'h0A5,1'b0,1'b0,1'b1},
    '{3'd5,1'b0,2'd0,1'b1,2'd1,1'b1,2'd1,1'b1,9'h0A5,1'b0,1'b0,1'b0,9'h000,1'b0,1'b0,1'b1},
    '{3'd3,1'b0,2'd0,1'b1,2'd1,1'b1,2'd2,1'b1,9'h080,1'b0,1'b0,1'b1,9'h080,1'b0,1'b1,1'b1},
    '{3'd4,1'b0,2'd0,1'b1,2'd1,1'b1,2'd3,1'b0,9'h133,1'b0,1'b0,1'b1,9'h133,1'b0,1'b0,1'b1},
    '{3'd3,1'b1,2'd2,1'b1,2'd3,1'b1,2'd1,1'b0,9'h005,1'b0,1'b0,1'b1,9'h005,1'b0,1'b0,1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx = 1'b1, inv = 1'b0;
  logic start_en = 1'b1, par_en = 1'b0, stop_en = 1'b1;
  logic [1:0] par_mode = 2'd0, stop_len = 2'd1, match_mode = 2'd0;
  logic [2:0] data_len = 3'd3;
  logic rx_en = 1'b1, one_shot = 1'b0, inhibit = 1'b0;
  logic ref_wr = 1'b0, ref_wd = 1'b0, flag_wr = 1'b0, irq_en = 1'b0;
  logic [2:0] flag_wd = 3'd0;
  logic out_ready = 1'b1;
  logic ref_bit, frm_err, par_err, ovr_err, err_irq, busy, out_valid;
  logic [8:0] out_data;

  int n_chk = 0, n_err = 0, got_cnt = 0;
  logic [8:0] got_word = '0;

  always #2.5 clk = ~clk;

  cfg_uart_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .invert_i(inv), .divisor_i(16'(DIV)),
    .start_en_i(start_en), .parity_en_i(par_en), .parity_mode_i(par_mode),
    .stop_en_i(stop_en), .stop_len_i(stop_len), .data_len_i(data_len),
    .match_mode_i(match_mode), .rx_enable_i(rx_en), .one_shot_i(one_shot),
    .inhibit_i(inhibit), .ref_bit_wr_i(ref_wr), .ref_bit_wdata_i(ref_wd),
    .ref_bit_o(ref_bit), .flag_wr_i(flag_wr), .flag_wdata_i(flag_wd),
    .err_irq_en_i(irq_en), .frame_err_o(frm_err), .parity_err_o(par_err),
    .overrun_err_o(ovr_err), .err_irq_o(err_irq), .busy_o(busy),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  always @(negedge clk) begin
    if (out_valid && out_ready) begin
      got_cnt++;
      got_word = out_data;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run hung act=1 exp=0");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic lvl, input int n);
    rx = lvl ^ inv;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int nb, input logic st, input logic pe,
                      input logic [1:0] pm, input logic badp, input logic sp,
                      input int slots, input logic bads);
    logic ones, pb;
    ones = ^(d & 9'((1 << nb) - 1));
    case (pm)
      2'd0: pb = ~ones;
      2'd1: pb = ones;
      2'd2: pb = 1'b1;
      default: pb = 1'b0;
    endcase
    if (st) drive(1'b0, DIV);
    for (int i = 0; i < nb; i++) drive(d[i], DIV);
    if (pe) drive(pb ^ badp, DIV);
    if (sp) drive(~bads, slots * DIV / 2);
    drive(1'b1, 2 * DIV);
  endtask

  task automatic send8(input logic [8:0] d);
    send(d, 8, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2, 1'b0);
  endtask

  task automatic write_flags(input logic [2:0] v);
    @(posedge clk); #1 flag_wr = 1'b1; flag_wd = v;
    @(posedge clk); #1 flag_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_ref(input logic v);
    @(posedge clk); #1 ref_wr = 1'b1; ref_wd = v;
    @(posedge clk); #1 ref_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk); #1 out_ready = v;
    @(negedge clk);
  endtask

  task automatic default_cfg();
    data_len = 3'd3; par_en = 1'b0; par_mode = 2'd0; stop_en = 1'b1;
    stop_len = 2'd1; start_en = 1'b1; match_mode = 2'd0;
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0 && busy == 1'b0, "R1 reset valid/busy", {out_valid, busy}, 0);
    chk({ovr_err, par_err, frm_err} == 3'b000 && err_irq == 1'b0, "R1 reset flags/irq",
        {ovr_err, par_err, frm_err, err_irq}, 0);
    chk(ref_bit == 1'b0, "R1 reset ref bit", ref_bit, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int k = 0; k < 16; k++) begin
      vec_t v;
      v = VECS[k];
      data_len = v.len; par_en = v.pen; par_mode = v.pmode; stop_en = v.sten;
      stop_len = v.slen; start_en = v.stren; match_mode = 2'd0;
      write_ref(v.ref_b);
      write_flags(3'b000);
      match_mode = v.mm;
      @(negedge clk);
      base = got_cnt;
      send(v.data, (v.len >= 3'd4) ? 9 : int'(v.len) + 5, v.stren, v.pen, v.pmode,
           v.badp, v.sten, int'(v.slen) + 1, v.bads);
      if (v.exp_st)
        chk(got_cnt == base + 1 && got_word == v.exp_w, $sformatf("R3 vec%0d word", k),
            got_word, v.exp_w);
      else
        chk(got_cnt == base, $sformatf("R7 vec%0d dropped", k), got_cnt - base, 0);
      chk(par_err == v.exp_pe, $sformatf("R4 vec%0d parity flag", k), par_err, v.exp_pe);
      chk(frm_err == v.exp_fe, $sformatf("R5 vec%0d frame flag", k), frm_err, v.exp_fe);
      chk(ref_bit == v.exp_ref, $sformatf("R7 vec%0d ref bit", k), ref_bit, v.exp_ref);
    end
    default_cfg();
    write_flags(3'b000);

    // R2: false start (line back high before half period) ignored
    base = got_cnt;
    drive(1'b0, 6);
    drive(1'b1, 3 * DIV);
    chk(got_cnt == base && busy == 1'b0, "R2 false start", got_cnt - base, 0);

    // R12: busy during frame, low after
    fork
      send8(9'h0C3);
      begin
        repeat (3 * DIV) @(negedge clk);
        chk(busy == 1'b1, "R12 busy mid frame", busy, 1);
      end
    join
    chk(busy == 1'b0 && got_word == 9'h0C3, "R12 busy cleared", busy, 0);

    // R8: inverted line
    @(negedge clk); inv = 1'b1; rx = 1'b0;
    repeat (8) @(negedge clk);
    base = got_cnt;
    send8(9'h096);
    chk(got_cnt == base + 1 && got_word == 9'h096, "R8 inverted word", got_word, 9'h096);
    @(negedge clk); inv = 1'b0; rx = 1'b1;
    repeat (8) @(negedge clk);

    // R9: disabled receiver ignores traffic
    rx_en = 1'b0;
    base = got_cnt;
    send8(9'h011);
    chk(got_cnt == base, "R9 disabled ignores", got_cnt - base, 0);
    // R9: one-shot accepts exactly one frame
    one_shot = 1'b1;
    send8(9'h055);
    chk(got_cnt == base + 1 && got_word == 9'h055, "R9 one-shot first", got_word, 9'h055);
    send8(9'h066);
    chk(got_cnt == base + 1, "R9 one-shot second ignored", got_cnt - base, 1);
    one_shot = 1'b0; rx_en = 1'b1;
    @(negedge clk);

    // R9: inhibit mid frame lets it finish, then blocks
    base = got_cnt;
    fork
      send8(9'h033);
      begin
        repeat (4 * DIV) @(negedge clk);
        inhibit = 1'b1;
      end
    join
    chk(got_cnt == base + 1 && got_word == 9'h033, "R9 inhibit completes current", got_word, 9'h033);
    send8(9'h044);
    chk(got_cnt == base + 1 && busy == 1'b0, "R9 inhibit blocks next", got_cnt - base, 1);
    inhibit = 1'b0;
    @(negedge clk);

    // R10: overrun keeps first word, drops second
    write_flags(3'b000);
    set_ready(1'b0);
    base = got_cnt;
    send8(9'h011);
    send8(9'h022);
    chk(ovr_err == 1'b1, "R10 overrun flag", ovr_err, 1);
    chk(out_valid == 1'b1 && out_data == 9'h011, "R10 held word", out_data, 9'h011);
    set_ready(1'b1);
    repeat (3) @(negedge clk);
    chk(got_cnt == base + 1 && got_word == 9'h011 && out_valid == 1'b0, "R10 drain",
        got_word, 9'h011);

    // R11: irq gating, clear and force
    irq_en = 1'b0;
    @(negedge clk);
    chk(err_irq == 1'b0, "R11 irq masked", err_irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk(err_irq == 1'b1, "R11 irq enabled", err_irq, 1);
    write_flags(3'b000);
    chk({ovr_err, par_err, frm_err} == 3'b000 && err_irq == 1'b0, "R11 clear",
        {ovr_err, par_err, frm_err}, 0);
    write_flags(3'b010);
    chk({ovr_err, par_err, frm_err} == 3'b010 && err_irq == 1'b1, "R11 force parity",
        {ovr_err, par_err, frm_err}, 2);
    write_flags(3'b000);
    chk(err_irq == 1'b0, "R11 cleared again", err_irq, 0);

    finish_run();
  end
endmodule